// File: doc/BRIEF.md
# Process-Tagged TLB Invalidation Sweeper

This block walks the full contents of a pair of translation buffers and finds every mapping owned by one process. It is used when an address space is torn down or its identifier is recycled. Software or a control unit pulses a start input together with a process identifier. The block then reads each stored entry through a synchronous read port, one entry per clock. For every entry that belongs to that process, it raises an invalidate strobe carrying the page-aligned virtual address of the entry.

The storage holds two banks, each of four ways of sixteen slots, so 128 entries in all. Each entry is presented as two 32-bit words, a high word and a low word. Entries marked global, and entries not marked valid, are never reported. The stored contents are not modified; acting on the invalidate strobes is left to the downstream logic. A single-cycle completion pulse closes every sweep.

Top module: `tlb_pid_sweep`

## Requirements
- R1: While reset is high, and in the first cycle after it, rd_en_o, inval_o and done_o are 0.
- R2: When start_i is high at a clock edge and no sweep is in progress, the block latches the process ID. In the next cycle it drives rd_en_o=1 with rd_addr_o=0.
- R3: rd_addr_o is the linear entry number {bank[6], way[5:4], slot[3:0]}, with the slot changing fastest. It rises by one on each of 128 consecutive cycles, from 0 to 127, while rd_en_o is 1. rd_en_o then falls.
- R4: The storage returns rd_hi_i/rd_lo_i one cycle after rd_en_o. The block takes the page number from rd_hi_i[31:13], the owner ID from rd_hi_i[7:0], the global flag from rd_lo_i[4] and the valid flag from rd_lo_i[3]. All other bits have no effect.
- R5: An entry is reported only if its valid flag is 1, its global flag is 0, and its owner ID equals the latched ID in all 8 bits.
- R6: inval_addr_o equals the page number shifted left by 13, so its bits [12:0] are zero.
- R7: The strobe for an entry is inval_o=1, lasting one cycle. It appears two cycles after the cycle in which that entry's address was on rd_addr_o. Strobes come in scan order, with exactly one per reported entry.
- R8: done_o is high for exactly one cycle, 130 cycles after the accepting edge. This is the same cycle that carries any strobe for entry 127. rd_en_o is 0 while done_o is high.
- R9: start_i is ignored from the accepting edge until the cycle before done_o. It causes no restart and no change of the latched ID.
- R10: Only pid_i[7:0] is used; pid_i[31:8] has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Sweep request |
| pid_i | input | 32 | Process ID; low byte is used |
| rd_en_o | output | 1 | Entry read request |
| rd_addr_o | output | 7 | Linear entry number {bank, way, slot} |
| rd_hi_i | input | 32 | High word of the entry read last cycle |
| rd_lo_i | input | 32 | Low word of the entry read last cycle |
| inval_o | output | 1 | Invalidate strobe |
| inval_addr_o | output | 32 | Page-aligned virtual address to invalidate |
| done_o | output | 1 | Sweep complete pulse |

## Verification
The bench fills the storage with several patterns and checks the sweep against each. Some patterns mix owners with valid and global flags; one has every entry owned by the target; one has owned entries that are all global or invalid; one has owners that differ from the target in a single bit. A design that compared fewer than eight ID bits, or ignored the global or valid flag, would emit extra strobes. A design with its read latency counted wrong would put strobes on the wrong cycle or pair them with the wrong entry. Entries 0 and 127 are forced to be owned, with page numbers 0 and all-ones, so that an off-by-one at either end of the walk, or a clipped top address bit, shows up. Start pulses in mid-sweep and in the final data cycle would, if honoured, restart the walk, change the ID or duplicate the completion pulse.

// File: rtl/tlb_sweep_pkg.sv
package tlb_sweep_pkg;
  localparam int WORD_W     = 32;
  localparam int PAGE_SHIFT = 13;
  localparam int PAGE_W     = WORD_W - PAGE_SHIFT;
  localparam int PID_W      = 8;
  localparam int LO_GLOBAL  = 4;
  localparam int LO_VALID   = 3;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [PID_W-1:0]  owner;
    logic              glob;
    logic              valid;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_sweep_seq.sv
module tlb_sweep_seq
  import tlb_sweep_pkg::*;
#(
  parameter int ENTRIES  = 128,
  parameter int PID_IN_W = 32,
  localparam int AW      = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [PID_IN_W-1:0] pid_i,
  input  logic                tail_busy_i,
  output logic                rd_en_o,
  output logic [AW-1:0]       rd_addr_o,
  output logic                last_o,
  output logic [PID_W-1:0]    pid_o
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(ENTRIES - 1);

  logic            scan_q;
  logic [AW-1:0]   ptr_q;
  logic [PID_W-1:0] pid_q;
  logic            accept;

  generate
    if (PID_IN_W > PID_W) begin : g_wide_pid
      logic unused_pid_hi;
      assign unused_pid_hi = ^pid_i[PID_IN_W-1:PID_W];
    end
  endgenerate

  assign accept = start_i && !scan_q && !tail_busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_q <= 1'b0;
      ptr_q  <= '0;
      pid_q  <= '0;
    end else if (accept) begin
      scan_q <= 1'b1;
      ptr_q  <= '0;
      pid_q  <= pid_i[PID_W-1:0];
    end else if (scan_q) begin
      if (ptr_q == LAST_ADDR) begin
        scan_q <= 1'b0;
        ptr_q  <= '0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign rd_en_o   = scan_q;
  assign rd_addr_o = ptr_q;
  assign last_o    = scan_q && (ptr_q == LAST_ADDR);
  assign pid_o     = pid_q;

  p_first_addr_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (rd_en_o && rd_addr_o == '0));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en_o && !last_o) |=> (rd_en_o && rd_addr_o == AW'($past(rd_addr_o) + 1'b1)));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (start_i && (scan_q || tail_busy_i)) |=> $stable(pid_q));
endmodule

// File: rtl/tlb_sweep_pipe.sv
module tlb_sweep_pipe (
  input  logic clk,
  input  logic rst,
  input  logic rd_en_i,
  input  logic last_i,
  output logic vld_o,
  output logic last_o
);
  logic vld_q;
  logic last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      vld_q  <= rd_en_i;
      last_q <= last_i;
    end
  end

  assign vld_o  = vld_q;
  assign last_o = last_q;

  p_last_aligned_r8: assert property (@(posedge clk) disable iff (rst)
    last_q |-> vld_q);
endmodule

// File: rtl/tlb_sweep_match.sv
module tlb_sweep_match
  import tlb_sweep_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic              last_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic [WORD_W-1:0] hi_i,
  input  logic [WORD_W-1:0] lo_i,
  output logic              inval_o,
  output logic [WORD_W-1:0] inval_addr_o,
  output logic              done_o
);
  tlb_entry_t ent;
  logic       hit;
  logic       inval_q;
  logic       done_q;
  logic [WORD_W-1:0] addr_q;
  logic       unused_fields;

  assign unused_fields = ^{hi_i[PAGE_SHIFT-1:PID_W],
                           lo_i[WORD_W-1:LO_GLOBAL+1],
                           lo_i[LO_VALID-1:0]};

  always_comb begin
    ent.page  = hi_i[WORD_W-1:PAGE_SHIFT];
    ent.owner = hi_i[PID_W-1:0];
    ent.glob  = lo_i[LO_GLOBAL];
    ent.valid = lo_i[LO_VALID];
  end

  assign hit = vld_i && ent.valid && !ent.glob && (ent.owner == pid_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      inval_q <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      inval_q <= hit;
      addr_q  <= hit ? {ent.page, {PAGE_SHIFT{1'b0}}} : '0;
      done_q  <= vld_i && last_i;
    end
  end

  assign inval_o      = inval_q;
  assign inval_addr_o = addr_q;
  assign done_o       = done_q;

  p_hit_flags_r5: assert property (@(posedge clk) disable iff (rst)
    inval_o |-> $past(vld_i && lo_i[LO_VALID] && !lo_i[LO_GLOBAL]));

  p_addr_from_page_r6: assert property (@(posedge clk) disable iff (rst)
    inval_o |-> (inval_addr_o[WORD_W-1:PAGE_SHIFT] == $past(hi_i[WORD_W-1:PAGE_SHIFT])
                 && inval_addr_o[PAGE_SHIFT-1:0] == '0));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: rtl/tlb_pid_sweep.sv
module tlb_pid_sweep
  import tlb_sweep_pkg::*;
#(
  parameter int BANKS    = 2,
  parameter int WAYS     = 4,
  parameter int SETS     = 16,
  parameter int PID_IN_W = 32,
  localparam int ENTRIES = BANKS * WAYS * SETS,
  localparam int AW      = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [PID_IN_W-1:0] pid_i,
  output logic                rd_en_o,
  output logic [AW-1:0]       rd_addr_o,
  input  logic [WORD_W-1:0]   rd_hi_i,
  input  logic [WORD_W-1:0]   rd_lo_i,
  output logic                inval_o,
  output logic [WORD_W-1:0]   inval_addr_o,
  output logic                done_o
);
  logic             last_issue;
  logic             data_vld;
  logic             data_last;
  logic [PID_W-1:0] pid_cur;

  tlb_sweep_seq #(
    .ENTRIES  (ENTRIES),
    .PID_IN_W (PID_IN_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .pid_i       (pid_i),
    .tail_busy_i (data_vld),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .last_o      (last_issue),
    .pid_o       (pid_cur)
  );

  tlb_sweep_pipe u_pipe (
    .clk     (clk),
    .rst     (rst),
    .rd_en_i (rd_en_o),
    .last_i  (last_issue),
    .vld_o   (data_vld),
    .last_o  (data_last)
  );

  tlb_sweep_match u_match (
    .clk          (clk),
    .rst          (rst),
    .vld_i        (data_vld),
    .last_i       (data_last),
    .pid_i        (pid_cur),
    .hi_i         (rd_hi_i),
    .lo_i         (rd_lo_i),
    .inval_o      (inval_o),
    .inval_addr_o (inval_addr_o),
    .done_o       (done_o)
  );

  p_quiet_at_done_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !rd_en_o);

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!rd_en_o && !inval_o && !done_o));
endmodule

// File: tb/tlb_pid_sweep_tb.sv
module tlb_pid_sweep_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] pid_i = '0;
  logic        rd_en;
  logic [6:0]  rd_addr;
  logic [31:0] rd_hi = '0;
  logic [31:0] rd_lo = '0;
  logic        inval;
  logic [31:0] inval_addr;
  logic        done;

  logic [31:0] mem_hi [N];
  logic [31:0] mem_lo [N];
  logic [31:0] exp_a [N];
  int          exp_e [N];
  int          exp_n;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_pid_sweep u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .pid_i(pid_i),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_hi_i(rd_hi), .rd_lo_i(rd_lo),
    .inval_o(inval), .inval_addr_o(inval_addr), .done_o(done)
  );

  always @(posedge clk) begin
    if (rd_en) begin
      rd_hi <= mem_hi[rd_addr];
      rd_lo <= mem_lo[rd_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 0 mixed, 1 all owned, 2 owned but global or invalid, 3 one-bit owner mismatch
  task automatic fill(input int mode, input logic [7:0] tgt);
    for (int e = 0; e < N; e++) begin
      logic [18:0] page;
      logic [7:0]  owner;
      logic        v, g;
      page = 19'(e * 1237 + mode * 4099 + 5);
      case (mode)
        0: begin
          owner = (e % 3 == 0) ? tgt : 8'(e * 11 + 1);
          v = (e % 4) != 1;
          g = (e % 5) == 2;
          if (e == 0)   begin page = '0;        owner = tgt; v = 1; g = 0; end
          if (e == N-1) begin page = 19'h7FFFF; owner = tgt; v = 1; g = 0; end
        end
        1: begin owner = tgt; v = 1; g = 0; end
        2: begin owner = tgt; v = e[0]; g = e[0]; end
        default: begin owner = tgt ^ (8'h01 << (e % 8)); v = 1; g = 0; end
      endcase
      mem_hi[e] = {page, 5'(e), owner};
      mem_lo[e] = {~27'(e), g, v, 3'(e)};
    end
  endtask

  task automatic build_expect(input logic [7:0] tgt);
    exp_n = 0;
    for (int e = 0; e < N; e++) begin
      if (mem_lo[e][3] && !mem_lo[e][4] && mem_hi[e][7:0] == tgt) begin
        exp_a[exp_n] = {mem_hi[e][31:13], 13'b0};
        exp_e[exp_n] = e;
        exp_n++;
      end
    end
  endtask

  task automatic run_scan(input logic [31:0] pid_word, input int poke_at,
                          input logic [31:0] poke_pid, input string tag);
    int seen = 0, done_cnt = 0, done_at = -1, addr_bad = 0;
    build_expect(pid_word[7:0]);
    @(negedge clk);
    start_i = 1'b1;
    pid_i   = pid_word;
    @(negedge clk);
    start_i = 1'b0;
    pid_i   = ~pid_word;
    for (int n = 1; n <= 132; n++) begin
      if (n == 1)
        chk(rd_en && rd_addr == 7'd0, {"R2 first read ", tag}, {rd_en, 24'd0, rd_addr}, 32'h8000_0000);
      if (n <= N) begin
        if (!(rd_en && rd_addr == 7'(n - 1))) addr_bad++;
      end else if (rd_en) addr_bad++;
      if (inval) begin
        if (seen < exp_n) begin
          chk(inval_addr == exp_a[seen], {"R6 address ", tag}, inval_addr, exp_a[seen]);
          chk(n - 3 == exp_e[seen], {"R7 entry timing ", tag}, 32'(n - 3), 32'(exp_e[seen]));
        end
        seen++;
      end
      if (done) begin done_cnt++; done_at = n; end
      if (n == poke_at) begin start_i = 1'b1; pid_i = poke_pid; end
      else start_i = 1'b0;
      @(negedge clk);
    end
    chk(addr_bad == 0, {"R3 R9 read sequence ", tag}, 32'(addr_bad), 0);
    chk(seen == exp_n, {"R4 R5 strobe count ", tag}, 32'(seen), 32'(exp_n));
    chk(done_cnt == 1, {"R8 done count ", tag}, 32'(done_cnt), 1);
    chk(done_at == 130, {"R8 done cycle ", tag}, 32'(done_at), 130);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_en && !inval && !done, "R1 during reset", {29'd0, rd_en, inval, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd_en && !inval && !done, "R1 after reset", {29'd0, rd_en, inval, done}, 0);

    fill(0, 8'h5A);
    run_scan(32'h0000_005A, 0, 0, "mixed");
    run_scan(32'hABCD_125A, 40, 32'h0000_0033, "R10 R9 high bits, mid poke");
    run_scan(32'h0000_005A, 129, 32'h0000_0000, "R9 poke in tail");
    fill(1, 8'h00);
    run_scan(32'h0000_0000, 0, 0, "all owned");
    fill(2, 8'hFF);
    run_scan(32'h0000_00FF, 0, 0, "global or invalid");
    fill(3, 8'h81);
    run_scan(32'h0000_0081, 0, 0, "one-bit owner mismatch");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule